// File: doc/BRIEF.md
# TFT Panel Sync and Data-Enable Timing Generator

This block produces the raster timing for a TFT panel in the pixel-clock domain. A horizontal counter steps once per clock across a line and a vertical counter steps once per line across a frame; both are compared against programmable windows to produce horizontal sync, vertical sync and data-enable. During the active area the block also reports the current pixel column and row and strobes a pixel request each time a new pixel has to be presented on the panel bus.

Every window comes from a 32-bit position word whose upper half is the first position at which the signal is active and whose lower half is the first position at which it is no longer active. A configuration word sets per-signal output polarity, reports which pixel-clock edge the panel samples on, and selects between parallel operation and a serial RGB mode in which one pixel occupies three clocks, so the active stretch of each line lasts three times as long. Position, total and configuration inputs are copied into shadow registers only when a frame wraps, so a change made mid-frame never tears the raster.

Top module: `tft_timing_gen`

## Requirements
- R1: Each position word holds the start in bits 31:16 and the end in bits 15:0; hsync is raw-active while the line position p satisfies start <= p < end of `hsync_pos`, and vsync likewise for the line number against `vsync_pos`.
- R2: The line position runs from 0 to (line total - 1), the line total being bits 31:16 of `totals`; on its wrap the line number steps, and the line number wraps to 0 after (frame total - 1), the frame total being bits 15:0 of `totals`.
- R3: de is raw-active only when the line position lies in the `hact_pos` window and the line number lies in the `vact_pos` window.
- R4: Configuration bit 8 inverts vsync, bit 9 inverts de, bit 11 inverts hsync, and bit 10 is driven onto `pclk_fall`.
- R5: When configuration bits 3:0 equal 4'hC (serial RGB), the horizontal active window keeps its start but lasts three times (end - start) clocks, and the line total grows by 2*(end - start); a window whose end is not above its start has zero width.
- R6: While de is raw-active, `px_x` is the pixel index from the start of the horizontal window (clock offset in parallel mode, clock offset divided by three in serial mode) and `px_y` is the line offset from the start of the vertical window; `pix_req` is high on every active clock in parallel mode and on every third active clock, starting with the first, in serial mode; all three are zero outside the active area.
- R7: `sof` is high for exactly the clocks in which both the line position and the line number are zero.
- R8: Inputs are captured on the first clock after reset and afterwards only on the clock on which the last position of the last line wraps; changes at any other time take effect from the following frame.
- R9: During reset every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 2*FW | Polarity, clock-edge and mode configuration |
| hsync_pos | input | 2*FW | Hsync start/end positions |
| vsync_pos | input | 2*FW | Vsync start/end lines |
| hact_pos | input | 2*FW | Horizontal active window start/end |
| vact_pos | input | 2*FW | Vertical active window start/end |
| totals | input | 2*FW | Line total (upper half) and frame total (lower half) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_req | output | 1 | Request for the next pixel |
| px_x | output | FW | Pixel column inside the active area |
| px_y | output | FW | Pixel row inside the active area |
| sof | output | 1 | Start-of-frame marker |
| pclk_fall | output | 1 | Panel samples on the falling pixel-clock edge |

## Verification
All outputs are decoded without further registers from the position counters and the shadowed settings, so each result belongs to the same clock as the counter state that produced it; a setting written mid-frame first shows in the clock after the frame-wrap edge, and the first capture is visible one clock after reset is released. The reference model advances its own counters and shadow copy at every rising edge and the bench compares all outputs at the following falling edge, which keeps both sides on the same counter state. Stimulus covers parallel and serial modes, inverted polarities, a mid-frame settings change and a window that fills the whole line.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;
   // configuration word bit positions
   localparam int POL_VS_BIT    = 8;
   localparam int POL_DE_BIT    = 9;
   localparam int PCLK_FALL_BIT = 10;
   localparam int POL_HS_BIT    = 11;
   localparam int MODE_LSB      = 0;
   localparam int MODE_W        = 4;
   localparam logic [MODE_W-1:0] MODE_SERIAL_RGB = 4'hC;
   // clocks per pixel in serial mode
   localparam int SERIAL_CLKS   = 3;
endpackage

// File: rtl/tft_tg_shadow.sv
module tft_tg_shadow
   import tft_tg_pkg::*;
#(
   parameter int FW        = 16,
   parameter int CW        = FW + 2,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [2*FW-1:0] cfg,
   input  logic [2*FW-1:0] hs_pos,
   input  logic [2*FW-1:0] vs_pos,
   input  logic [2*FW-1:0] ha_pos,
   input  logic [2*FW-1:0] va_pos,
   input  logic [2*FW-1:0] tot,
   output logic [FW-1:0]   hs_s,
   output logic [FW-1:0]   hs_e,
   output logic [FW-1:0]   vs_s,
   output logic [FW-1:0]   vs_e,
   output logic [CW-1:0]   ha_s,
   output logic [CW-1:0]   ha_e,
   output logic [CW-1:0]   htot,
   output logic [FW-1:0]   va_s,
   output logic [FW-1:0]   va_e,
   output logic [FW-1:0]   vtot,
   output logic            inv_hs,
   output logic            inv_vs,
   output logic            inv_de,
   output logic            pclk_fall,
   output logic            serial
);
   localparam int RW = 2 * FW;
   localparam int XW = CW - FW;

   if (FW < 4)       begin : g_chk_fw $error("tft_tg_shadow: FW must be at least 4"); end
   if (XW < 2)       begin : g_chk_cw $error("tft_tg_shadow: CW must exceed FW by two"); end
   if (RW < 12)      begin : g_chk_rw $error("tft_tg_shadow: configuration word too narrow"); end

   logic [CW-1:0] has_x, hae_x, toth_x, hae_n, htot_n;
   logic          ser_n;

   assign has_x  = {{XW{1'b0}}, ha_pos[RW-1:FW]};
   assign hae_x  = {{XW{1'b0}}, ha_pos[FW-1:0]};
   assign toth_x = {{XW{1'b0}}, tot[RW-1:FW]};

   if (SERIAL_EN) begin : g_serial
      logic [CW-1:0] span;
      assign ser_n  = (cfg[MODE_LSB +: MODE_W] == MODE_SERIAL_RGB);
      assign span   = (hae_x > has_x) ? (hae_x - has_x) : '0;
      assign hae_n  = ser_n ? (has_x + span + (span << 1)) : hae_x;
      assign htot_n = ser_n ? (toth_x + (span << 1)) : toth_x;
   end else begin : g_parallel
      logic unused_mode;
      assign unused_mode = ^cfg[MODE_LSB +: MODE_W];
      assign ser_n  = 1'b0;
      assign hae_n  = hae_x;
      assign htot_n = toth_x;
   end

   logic unused_cfg_hi;
   assign unused_cfg_hi = ^{cfg[RW-1:POL_HS_BIT+1], cfg[POL_VS_BIT-1:MODE_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_s <= '0; hs_e <= '0; vs_s <= '0; vs_e <= '0;
         ha_s <= '0; ha_e <= '0; htot <= '0;
         va_s <= '0; va_e <= '0; vtot <= '0;
         inv_hs <= 1'b0; inv_vs <= 1'b0; inv_de <= 1'b0;
         pclk_fall <= 1'b0; serial <= 1'b0;
      end else if (load) begin
         hs_s <= hs_pos[RW-1:FW]; hs_e <= hs_pos[FW-1:0];
         vs_s <= vs_pos[RW-1:FW]; vs_e <= vs_pos[FW-1:0];
         ha_s <= has_x; ha_e <= hae_n; htot <= htot_n;
         va_s <= va_pos[RW-1:FW]; va_e <= va_pos[FW-1:0];
         vtot <= tot[FW-1:0];
         inv_hs    <= cfg[POL_HS_BIT];
         inv_vs    <= cfg[POL_VS_BIT];
         inv_de    <= cfg[POL_DE_BIT];
         pclk_fall <= cfg[PCLK_FALL_BIT];
         serial    <= ser_n;
      end
   end

   // R8: settings only move on a load clock
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(htot) && $stable(vtot) && $stable(ha_e) && $stable(hs_e)
                 && $stable(inv_hs) && $stable(serial)));
endmodule

// File: rtl/tft_tg_hcount.sv
module tft_tg_hcount
   import tft_tg_pkg::*;
#(
   parameter int FW = 16,
   parameter int CW = FW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          serial,
   input  logic [CW-1:0] htot,
   input  logic [CW-1:0] ha_s,
   input  logic [CW-1:0] ha_e,
   output logic [CW-1:0] hcnt,
   output logic          h_last,
   output logic          h_in,
   output logic          ph_first,
   output logic [FW-1:0] x_idx
);
   localparam logic [CW:0]   ONE_W  = 1;
   localparam logic [CW-1:0] ONE_C  = 1;
   localparam logic [FW-1:0] ONE_F  = 1;
   localparam logic [1:0]    PH_LAST = 2'(SERIAL_CLKS - 1);

   logic [1:0] ph;

   assign h_last   = (({1'b0, hcnt} + ONE_W) >= {1'b0, htot});
   assign h_in     = (hcnt >= ha_s) && (hcnt < ha_e);
   assign ph_first = (ph == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0; ph <= '0; x_idx <= '0;
      end else if (!run || h_last) begin
         hcnt <= '0; ph <= '0; x_idx <= '0;
      end else begin
         hcnt <= hcnt + ONE_C;
         if (!h_in) begin
            ph <= '0; x_idx <= '0;
         end else if (serial && ph != PH_LAST) begin
            ph <= ph + 2'd1;
         end else begin
            ph <= '0; x_idx <= x_idx + ONE_F;
         end
      end
   end

   // R2: the line position steps by one until its last clock
   a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !h_last) |=> (hcnt == $past(hcnt) + ONE_C));
   // R6: the serial phase never passes the third clock
   a_r6_phase_max: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= PH_LAST);
   // R6: outside serial mode each active clock is a new pixel
   a_r6_par_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !serial |=> (ph == 2'd0) || serial);
endmodule

// File: rtl/tft_tg_vcount.sv
module tft_tg_vcount #(
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [FW-1:0] vtot,
   input  logic [FW-1:0] va_s,
   input  logic [FW-1:0] va_e,
   output logic [FW-1:0] vcnt,
   output logic          v_last,
   output logic          v_in,
   output logic [FW-1:0] y_idx
);
   localparam logic [FW:0]   ONE_W = 1;
   localparam logic [FW-1:0] ONE_F = 1;

   assign v_last = (({1'b0, vcnt} + ONE_W) >= {1'b0, vtot});
   assign v_in   = (vcnt >= va_s) && (vcnt < va_e);
   assign y_idx  = v_in ? (vcnt - va_s) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                vcnt <= '0;
      else if (!run)             vcnt <= '0;
      else if (step && v_last)   vcnt <= '0;
      else if (step)             vcnt <= vcnt + ONE_F;
   end

   // R2: the line number only moves on a line wrap
   a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(vcnt));
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
   import tft_tg_pkg::*;
#(
   parameter int FW        = 16,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2*FW-1:0] cfg_word,
   input  logic [2*FW-1:0] hsync_pos,
   input  logic [2*FW-1:0] vsync_pos,
   input  logic [2*FW-1:0] hact_pos,
   input  logic [2*FW-1:0] vact_pos,
   input  logic [2*FW-1:0] totals,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic            pix_req,
   output logic [FW-1:0]   px_x,
   output logic [FW-1:0]   px_y,
   output logic            sof,
   output logic            pclk_fall
);
   localparam int CW = FW + 2;
   localparam logic [CW-1:0] ONE_C = 1;

   logic [FW-1:0] hs_s, hs_e, vs_s, vs_e, va_s, va_e, vtot, vcnt, y_idx, x_idx;
   logic [CW-1:0] ha_s, ha_e, htot, hcnt;
   logic inv_hs, inv_vs, inv_de, serial;
   logic h_last, h_in, ph_first, v_last, v_in;
   logic armed, load;

   assign load = !armed || (h_last && v_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   tft_tg_shadow #(.FW(FW), .CW(CW), .SERIAL_EN(SERIAL_EN)) i_shadow (
      .clk(clk), .rst_n(rst_n), .load(load), .cfg(cfg_word),
      .hs_pos(hsync_pos), .vs_pos(vsync_pos), .ha_pos(hact_pos),
      .va_pos(vact_pos), .tot(totals),
      .hs_s(hs_s), .hs_e(hs_e), .vs_s(vs_s), .vs_e(vs_e),
      .ha_s(ha_s), .ha_e(ha_e), .htot(htot),
      .va_s(va_s), .va_e(va_e), .vtot(vtot),
      .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de),
      .pclk_fall(pclk_fall), .serial(serial));

   tft_tg_hcount #(.FW(FW), .CW(CW)) i_hcount (
      .clk(clk), .rst_n(rst_n), .run(armed), .serial(serial),
      .htot(htot), .ha_s(ha_s), .ha_e(ha_e),
      .hcnt(hcnt), .h_last(h_last), .h_in(h_in),
      .ph_first(ph_first), .x_idx(x_idx));

   tft_tg_vcount #(.FW(FW)) i_vcount (
      .clk(clk), .rst_n(rst_n), .run(armed), .step(h_last),
      .vtot(vtot), .va_s(va_s), .va_e(va_e),
      .vcnt(vcnt), .v_last(v_last), .v_in(v_in), .y_idx(y_idx));

   logic hs_raw, vs_raw, de_raw;
   assign hs_raw = (hcnt >= {2'b00, hs_s}) && (hcnt < {2'b00, hs_e});
   assign vs_raw = (vcnt >= vs_s) && (vcnt < vs_e);
   assign de_raw = h_in && v_in;

   assign hsync   = hs_raw ^ inv_hs;
   assign vsync   = vs_raw ^ inv_vs;
   assign de      = de_raw ^ inv_de;
   assign pix_req = de_raw && ph_first;
   assign px_x    = de_raw ? x_idx : '0;
   assign px_y    = de_raw ? y_idx : '0;
   assign sof     = armed && (hcnt == '0) && (vcnt == '0);

   // R7: with lines longer than one clock the frame marker lasts one clock
   a_r7_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && htot > ONE_C) |=> !sof);
   // R6: a pixel request only falls inside the active window
   a_r6_req_window: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |-> (h_in && v_in && armed));
endmodule

// File: tb/test_tft_timing_gen.sv
module test_tft_timing_gen;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 16;
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] cfg_word, hsync_pos, vsync_pos, hact_pos, vact_pos, totals;
   logic hsync, vsync, de, pix_req, sof, pclk_fall;
   logic [FW-1:0] px_x, px_y;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tft_timing_gen #(.FW(FW), .SERIAL_EN(1'b1)) i_tft_timing_gen (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .hsync_pos(hsync_pos), .vsync_pos(vsync_pos),
      .hact_pos(hact_pos), .vact_pos(vact_pos), .totals(totals),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
      .px_x(px_x), .px_y(px_y), .sof(sof), .pclk_fall(pclk_fall));

   // behavioural reference state
   int  m_h, m_v, m_armed;
   int  m_hss, m_hse, m_vss, m_vse, m_has, m_hae, m_vas, m_vae, m_ht, m_vt;
   int  m_ser, m_ihs, m_ivs, m_ide, m_pcf;

   task automatic m_capture();
      int span;
      m_hss = int'(hsync_pos[31:16]); m_hse = int'(hsync_pos[15:0]);
      m_vss = int'(vsync_pos[31:16]); m_vse = int'(vsync_pos[15:0]);
      m_has = int'(hact_pos[31:16]);  m_hae = int'(hact_pos[15:0]);
      m_vas = int'(vact_pos[31:16]);  m_vae = int'(vact_pos[15:0]);
      m_ht  = int'(totals[31:16]);    m_vt  = int'(totals[15:0]);
      m_ser = (cfg_word[3:0] == 4'hC) ? 1 : 0;
      m_ihs = int'(cfg_word[11]); m_ivs = int'(cfg_word[8]);
      m_ide = int'(cfg_word[9]);  m_pcf = int'(cfg_word[10]);
      if (m_ser == 1) begin
         span  = (m_hae > m_has) ? m_hae - m_has : 0;
         m_hae = m_has + 3 * span;
         m_ht  = m_ht + 2 * span;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h = 0; m_v = 0; m_armed = 0;
         m_hss = 0; m_hse = 0; m_vss = 0; m_vse = 0; m_has = 0; m_hae = 0;
         m_vas = 0; m_vae = 0; m_ht = 0; m_vt = 0;
         m_ser = 0; m_ihs = 0; m_ivs = 0; m_ide = 0; m_pcf = 0;
      end else if (m_armed == 0) begin
         m_capture();
         m_armed = 1;
      end else if (m_h + 1 >= m_ht) begin
         m_h = 0;
         if (m_v + 1 >= m_vt) begin
            m_v = 0;
            m_capture();
         end else begin
            m_v = m_v + 1;
         end
      end else begin
         m_h = m_h + 1;
      end
   end

   task automatic chk(input string what, input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at h=%0d v=%0d: actual %0d expected %0d", req, what, m_h, m_v, act, exp);
      end
   endtask

   // compare every output away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int hin, vin, dr, e_req, e_x, e_y;
         hin = (m_armed == 1 && m_h >= m_has && m_h < m_hae) ? 1 : 0;
         vin = (m_armed == 1 && m_v >= m_vas && m_v < m_vae) ? 1 : 0;
         dr  = hin & vin;
         if (dr == 1) begin
            e_x   = (m_ser == 1) ? (m_h - m_has) / 3 : (m_h - m_has);
            e_req = (m_ser == 1) ? (((m_h - m_has) % 3 == 0) ? 1 : 0) : 1;
            e_y   = m_v - m_vas;
         end else begin
            e_x = 0; e_req = 0; e_y = 0;
         end
         chk("hsync", "R1 R4 R8", int'(hsync),
             ((m_h >= m_hss && m_h < m_hse) ? 1 : 0) ^ m_ihs);
         chk("vsync", "R1 R2 R4", int'(vsync),
             ((m_v >= m_vss && m_v < m_vse) ? 1 : 0) ^ m_ivs);
         chk("de", "R3 R4", int'(de), dr ^ m_ide);
         chk("pix_req", "R6 R5", int'(pix_req), e_req);
         chk("px_x", "R6 R5", int'(px_x), e_x);
         chk("px_y", "R6 R2", int'(px_y), e_y);
         chk("sof", "R7 R2", int'(sof), (m_armed == 1 && m_h == 0 && m_v == 0) ? 1 : 0);
         chk("pclk_fall", "R4 R8", int'(pclk_fall), m_pcf);
      end
   end

   task automatic set_timing(input int hsw, input int blw, input int w, input int elw,
                             input int vsw, input int bfw, input int ht, input int efw);
      hsync_pos = {16'd0, 16'(hsw)};
      vsync_pos = {16'd0, 16'(vsw)};
      hact_pos  = {16'(hsw + blw), 16'(hsw + blw + w)};
      vact_pos  = {16'(vsw + bfw), 16'(vsw + bfw + ht)};
      totals    = {16'(hsw + blw + w + elw), 16'(vsw + bfw + ht + efw)};
   endtask

   initial begin
      cfg_word = 32'h0000_0000;
      set_timing(2, 3, 4, 2, 1, 2, 3, 1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R9: outputs quiet during reset
      chk("hsync", "R9", int'(hsync), 0);
      chk("vsync", "R9", int'(vsync), 0);
      chk("de", "R9", int'(de), 0);
      chk("pix_req", "R9", int'(pix_req), 0);
      chk("sof", "R9", int'(sof), 0);
      chk("px_x", "R9", int'(px_x), 0);
      chk("pclk_fall", "R9", int'(pclk_fall), 0);
      rst_n = 1'b1;
      // parallel mode, two frames of 11x7
      repeat (160) @(negedge clk);
      // R8 and R4: polarity change lands mid-frame, applies next frame
      cfg_word = 32'h0000_0F00;
      repeat (170) @(negedge clk);
      // R5: serial RGB mode
      cfg_word = 32'h0000_000C;
      repeat (300) @(negedge clk);
      // new geometry, sync not at zero, serial off, hsync inverted
      cfg_word  = 32'h0000_0800;
      set_timing(3, 1, 5, 3, 2, 1, 4, 2);
      hsync_pos = {16'd1, 16'd3};
      vsync_pos = {16'd1, 16'd2};
      repeat (250) @(negedge clk);
      // whole line active, serial mode, window at line start
      cfg_word  = 32'h0000_020C;
      hact_pos  = {16'd0, 16'd2};
      totals    = {16'd2, 16'd3};
      vact_pos  = {16'd0, 16'd2};
      repeat (200) @(negedge clk);
      // empty window: end below start gives zero width
      cfg_word  = 32'h0000_000C;
      hact_pos  = {16'd4, 16'd2};
      totals    = {16'd6, 16'd3};
      repeat (120) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule